// File: doc/BRIEF.md
# Buck Regulator Fault Supervisor

This block is the digital start-up and protection sequencer of a synchronous step-down converter. It is clocked once per switching period and sees the analog side only as flags: the enable level, a supply-lockout-good flag, and comparator results for feedback under the low limit, over the high limit, outside the power-good window, a cycle-by-cycle current-limit trip, a shorted upper switch, an over-temperature condition (with a separate cool-down flag) and a bad feedback pin.

From these it produces a soft-start ramp code that rises one step per switching cycle, a modulator enable, a lower-switch synchronous enable, a power-good level, a request to discharge the enable pin, and a latched fault flag. Each protection is qualified by its own count of consecutive cycles and is either active during the ramp or only after it. The lower switch stays off until late in the ramp, so an output that is already partly charged is not pulled down.

Top module: `bk_supervisor`

## Requirements
- R1: After reset, or on the cycle after enable is sampled low, the ramp code is 0 and the modulator enable, lower-switch enable, power-good, discharge request and fault flag are all 0.
- R2: While the bad-feedback-pin flag is high at start-up the ramp is not released: the code stays 0 and the modulator stays disabled; once the flag clears the ramp starts.
- R3: The ramp code rises by exactly 1 per switching cycle from 0 up to SS_CYCLES (default 100) and then holds; the modulator enable is 1 during the ramp and afterwards.
- R4: The lower-switch enable is 0 while the ramp code is below 19*SS_CYCLES/25 (76 by default) and 1 from that code onward.
- R5: Power-good is 0 until the ramp code has reached SS_CYCLES, and 1 once it has, while the feedback is inside its window.
- R6: Power-good falls after the out-of-window flag has been high for 2 consecutive cycles; a single cycle leaves it high; this never sets the fault flag.
- R7: The undervoltage flag sets the fault flag after 16 consecutive cycles once the ramp is complete (15 do not); during the ramp it has no effect.
- R8: The overvoltage flag sets the fault flag after 2 consecutive cycles (1 does not), during the ramp as well as after it.
- R9: The current-limit flag sets the fault flag after 16 consecutive cycles (15 do not), during the ramp as well as after it; if the 16th cycle coincides with the last ramp step, the fault wins and power-good never rises.
- R10: The shorted-upper-switch flag, while the lower-switch enable is 1, sets the fault flag after a single cycle.
- R11: The over-temperature flag sets the fault flag after a single cycle once the ramp is complete; a new start is refused until the cool-down flag has been seen.
- R12: With the fault flag set, the modulator and lower switch are off and the discharge request is 1; the fault stays set while enable stays high and clears only when enable goes low, after which enable high starts a new ramp from 0.
- R13: Loss of the supply-lockout-good flag clears the ramp code and the fault flag on the next cycle.
- R14: A qualification count restarts from zero when its flag is absent for one cycle (10 cycles, a one-cycle gap, then 10 more cycles of current limit give no fault).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Switching clock |
| rst | input | 1 | Synchronous active-high reset |
| en_i | input | 1 | Enable level |
| uvlo_ok_i | input | 1 | Supply above lockout threshold |
| fb_under_i | input | 1 | Feedback below undervoltage limit |
| fb_over_i | input | 1 | Feedback above overvoltage limit |
| fb_out_win_i | input | 1 | Feedback outside power-good window |
| ilim_trip_i | input | 1 | Cycle-by-cycle current limit tripped |
| hs_short_i | input | 1 | Switch node high with lower switch on |
| otp_hot_i | input | 1 | Die above over-temperature limit |
| otp_cool_i | input | 1 | Die below restart temperature |
| fb_pin_bad_i | input | 1 | Feedback pin open or shorted |
| ss_code_o | output | $clog2(SS_CYCLES+1) | Soft-start ramp code |
| pwm_en_o | output | 1 | Modulator enable |
| ls_en_o | output | 1 | Lower-switch synchronous enable |
| pgood_o | output | 1 | Power-good |
| en_dis_o | output | 1 | Enable-pin discharge request |
| fault_o | output | 1 | Latched fault |

## Verification
Two functions can land on the same edge: the final ramp step that would raise power-good, and the 16th current-limit cycle that latches a fault. The bench starts the current-limit flag exactly 16 cycles before the ramp reaches full scale and requires the fault flag set with power-good never seen high. A second coincidence drives overvoltage and out-of-window together for two cycles, so the fault latch and the power-good drop qualify on the same edge; both outcomes are checked.

// File: rtl/bk_sup_pkg.sv
package bk_sup_pkg;

    typedef enum logic [2:0] {
        ST_OFF,
        ST_CHECK,
        ST_RAMP,
        ST_RUN,
        ST_FAULT
    } sup_state_e;

    // indices of the counted protections
    localparam int Q_UV = 0;
    localparam int Q_OV = 1;
    localparam int Q_OC = 2;
    localparam int Q_PG = 3;
    localparam int NQ   = 4;

    typedef struct packed {
        logic uv;
        logic ov;
        logic oc;
        logic sc;
        logic ot;
    } fault_vec_t;

    function automatic int ramp_point(input int full, input int num, input int den);
        return (full * num) / den;
    endfunction

    function automatic logic is_active(input sup_state_e s);
        return (s == ST_RAMP) || (s == ST_RUN);
    endfunction

endpackage

// File: rtl/bk_qual_cnt.sv
module bk_qual_cnt #(
    parameter int unsigned N = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic cond_i,
    output logic trip_o
);
    localparam int unsigned CW = (N < 2) ? 1 : $clog2(N + 1);

    logic [CW-1:0] cnt;

    // trip on the N-th consecutive cycle the condition is present
    assign trip_o = cond_i && (cnt == CW'(N - 1));

    always_ff @(posedge clk) begin
        if (rst || !cond_i) begin
            cnt <= '0;
        end else if (cnt != CW'(N - 1)) begin
            cnt <= cnt + CW'(1);
        end
    end
endmodule

// File: rtl/bk_ramp.sv
module bk_ramp #(
    parameter int unsigned SS_CYCLES = 100,
    localparam int unsigned SS_W = $clog2(SS_CYCLES + 1)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            clr_i,
    input  logic            adv_i,
    output logic [SS_W-1:0] code_o,
    output logic            last_o
);
    logic [SS_W-1:0] code;

    assign code_o = code;
    assign last_o = (code == SS_W'(SS_CYCLES - 1));

    always_ff @(posedge clk) begin
        if (rst || clr_i) begin
            code <= '0;
        end else if (adv_i && (code != SS_W'(SS_CYCLES))) begin
            code <= code + SS_W'(1);
        end
    end
endmodule

// File: rtl/bk_seq.sv
module bk_seq
    import bk_sup_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       en_i,
    input  logic       uvlo_ok_i,
    input  logic       fb_bad_i,
    input  logic       ot_block_i,
    input  logic       fault_i,
    input  logic       ramp_last_i,
    output sup_state_e state_o,
    output sup_state_e state_nx_o
);
    sup_state_e st, nx;

    always_comb begin
        nx = st;
        if (!uvlo_ok_i) begin
            nx = ST_OFF;
        end else begin
            unique case (st)
                ST_OFF:   if (en_i && !ot_block_i) nx = ST_CHECK;
                ST_CHECK: if (!en_i) nx = ST_OFF;
                          else if (!fb_bad_i) nx = ST_RAMP;
                ST_RAMP:  if (!en_i) nx = ST_OFF;
                          else if (fault_i) nx = ST_FAULT;
                          else if (ramp_last_i) nx = ST_RUN;
                ST_RUN:   if (!en_i) nx = ST_OFF;
                          else if (fault_i) nx = ST_FAULT;
                ST_FAULT: if (!en_i) nx = ST_OFF;
                default:  nx = ST_OFF;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st <= ST_OFF;
        else     st <= nx;
    end

    assign state_o    = st;
    assign state_nx_o = nx;
endmodule

// File: rtl/bk_supervisor.sv
module bk_supervisor
    import bk_sup_pkg::*;
#(
    parameter int unsigned SS_CYCLES = 100,
    parameter int unsigned UV_N      = 16,
    parameter int unsigned OV_N      = 2,
    parameter int unsigned OC_N      = 16,
    parameter int unsigned PG_N      = 2,
    localparam int unsigned SS_W     = $clog2(SS_CYCLES + 1)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            en_i,
    input  logic            uvlo_ok_i,
    input  logic            fb_under_i,
    input  logic            fb_over_i,
    input  logic            fb_out_win_i,
    input  logic            ilim_trip_i,
    input  logic            hs_short_i,
    input  logic            otp_hot_i,
    input  logic            otp_cool_i,
    input  logic            fb_pin_bad_i,
    output logic [SS_W-1:0] ss_code_o,
    output logic            pwm_en_o,
    output logic            ls_en_o,
    output logic            pgood_o,
    output logic            en_dis_o,
    output logic            fault_o
);
    localparam int unsigned LS_PT = ramp_point(SS_CYCLES, 19, 25);
    localparam int unsigned QN [NQ] = '{UV_N, OV_N, OC_N, PG_N};

    sup_state_e      state, state_nx;
    logic            active, run;
    logic [NQ-1:0]   qcond, qtrip;
    fault_vec_t      fv;
    logic            any_fault;
    logic            ot_block, pg_low;
    logic            ramp_last;
    logic [SS_W-1:0] code;

    assign active = is_active(state);
    assign run    = (state == ST_RUN);

    // qualification conditions, gated by the phase each protection is live in
    assign qcond[Q_UV] = fb_under_i   && run;
    assign qcond[Q_OV] = fb_over_i    && active;
    assign qcond[Q_OC] = ilim_trip_i  && active;
    assign qcond[Q_PG] = fb_out_win_i && run;

    for (genvar g = 0; g < NQ; g++) begin : g_qual
        bk_qual_cnt #(.N(QN[g])) u_q (
            .clk    (clk),
            .rst    (rst),
            .cond_i (qcond[g]),
            .trip_o (qtrip[g])
        );
    end

    always_comb begin
        fv.uv = qtrip[Q_UV];
        fv.ov = qtrip[Q_OV];
        fv.oc = qtrip[Q_OC];
        fv.sc = hs_short_i && ls_en_o;
        fv.ot = otp_hot_i && run;
    end
    assign any_fault = |fv;

    bk_seq u_seq (
        .clk         (clk),
        .rst         (rst),
        .en_i        (en_i),
        .uvlo_ok_i   (uvlo_ok_i),
        .fb_bad_i    (fb_pin_bad_i),
        .ot_block_i  (ot_block),
        .fault_i     (any_fault),
        .ramp_last_i (ramp_last),
        .state_o     (state),
        .state_nx_o  (state_nx)
    );

    bk_ramp #(.SS_CYCLES(SS_CYCLES)) u_ramp (
        .clk    (clk),
        .rst    (rst),
        .clr_i  (!is_active(state_nx)),
        .adv_i  (state == ST_RAMP),
        .code_o (code),
        .last_o (ramp_last)
    );

    // over-temperature restart interlock
    always_ff @(posedge clk) begin
        if (rst)             ot_block <= 1'b0;
        else if (otp_hot_i)  ot_block <= 1'b1;
        else if (otp_cool_i) ot_block <= 1'b0;
    end

    // power-good drop holder
    always_ff @(posedge clk) begin
        if (rst || !run)        pg_low <= 1'b0;
        else if (qtrip[Q_PG])   pg_low <= 1'b1;
        else if (!fb_out_win_i) pg_low <= 1'b0;
    end

    assign ss_code_o = code;
    assign pwm_en_o  = active;
    assign ls_en_o   = run || ((state == ST_RAMP) && (code >= SS_W'(LS_PT)));
    assign pgood_o   = run && !pg_low;
    assign en_dis_o  = (state == ST_FAULT);
    assign fault_o   = (state == ST_FAULT);
endmodule

// File: rtl/bk_supervisor_chk.sv
module bk_supervisor_chk #(
    parameter int unsigned SS_CYCLES = 100,
    localparam int unsigned SS_W     = $clog2(SS_CYCLES + 1)
) (
    input logic            clk,
    input logic            rst,
    input logic            en_i,
    input logic            uvlo_ok_i,
    input logic            hs_short_i,
    input logic [SS_W-1:0] ss_code_o,
    input logic            pwm_en_o,
    input logic            ls_en_o,
    input logic            pgood_o,
    input logic            en_dis_o,
    input logic            fault_o
);
    // R12
    fault_off_chk: assert property (@(posedge clk) disable iff (rst)
        fault_o |-> (!pwm_en_o && !ls_en_o && en_dis_o));

    // R12
    fault_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (fault_o && en_i && uvlo_ok_i) |=> fault_o);

    // R4
    ls_needs_pwm_chk: assert property (@(posedge clk) disable iff (rst)
        ls_en_o |-> pwm_en_o);

    // R5
    pg_after_ramp_chk: assert property (@(posedge clk) disable iff (rst)
        pgood_o |-> (ss_code_o == SS_W'(SS_CYCLES)));

    // R13
    uvlo_clear_chk: assert property (@(posedge clk) disable iff (rst)
        !uvlo_ok_i |=> (ss_code_o == '0 && !fault_o));

    // R1
    standby_chk: assert property (@(posedge clk) disable iff (rst)
        !en_i |=> (!pwm_en_o && !fault_o));

    // R10
    short_fast_chk: assert property (@(posedge clk) disable iff (rst)
        (hs_short_i && ls_en_o && en_i && uvlo_ok_i) |=> fault_o);

    // R3
    ramp_step_chk: assert property (@(posedge clk) disable iff (rst)
        (pwm_en_o && ss_code_o != SS_W'(SS_CYCLES) && en_i && uvlo_ok_i && $past(pwm_en_o))
        |-> (ss_code_o == $past(ss_code_o) + SS_W'(1)));
endmodule

bind bk_supervisor bk_supervisor_chk #(.SS_CYCLES(SS_CYCLES)) u_chk (.*);

// File: tb/bk_supervisor_test.sv
`timescale 1ns/1ps
module bk_supervisor_test;
    localparam int SSC = 100;
    localparam int LSP = 76;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic en = 0, uvlo = 0, fb_under = 0, fb_over = 0, fb_ow = 0, ilim = 0;
    logic hs_short = 0, ot_hot = 0, ot_cool = 0, fb_bad = 0;
    logic [6:0] ss;
    logic pwm_en, ls_en, pgood, en_dis, fault;

    int checks = 0, fails = 0;
    bit done = 0;

    always #4 clk = ~clk;

    bk_supervisor uut (
        .clk(clk), .rst(rst), .en_i(en), .uvlo_ok_i(uvlo),
        .fb_under_i(fb_under), .fb_over_i(fb_over), .fb_out_win_i(fb_ow),
        .ilim_trip_i(ilim), .hs_short_i(hs_short), .otp_hot_i(ot_hot),
        .otp_cool_i(ot_cool), .fb_pin_bad_i(fb_bad),
        .ss_code_o(ss), .pwm_en_o(pwm_en), .ls_en_o(ls_en), .pgood_o(pgood),
        .en_dis_o(en_dis), .fault_o(fault)
    );

    // vector: [15:12] flag select, [11:4] cycles held, [1] fault expected, [0] pgood expected
    // select: 0 under, 1 over, 2 current limit, 3 short, 4 hot, 5 out of window
    localparam logic [15:0] VEC [10] = '{
        {4'd0, 8'd15, 2'b0, 2'b01},
        {4'd0, 8'd16, 2'b0, 2'b10},
        {4'd1, 8'd1,  2'b0, 2'b01},
        {4'd1, 8'd2,  2'b0, 2'b10},
        {4'd2, 8'd15, 2'b0, 2'b01},
        {4'd2, 8'd16, 2'b0, 2'b10},
        {4'd3, 8'd1,  2'b0, 2'b10},
        {4'd4, 8'd1,  2'b0, 2'b10},
        {4'd5, 8'd1,  2'b0, 2'b01},
        {4'd5, 8'd2,  2'b0, 2'b00}
    };
    localparam string VREQ [10] = '{"R7","R7","R8","R8","R9","R9","R10","R11","R6","R6"};

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic set_flag(input int sel, input logic v);
        case (sel)
            0: fb_under = v;
            1: fb_over  = v;
            2: ilim     = v;
            3: hs_short = v;
            4: ot_hot   = v;
            default: fb_ow = v;
        endcase
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic summary();
        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    endtask

    // en low, cool-down pulse, en high, wait for ramp end
    task automatic restart();
        en = 0; cyc(2);
        ot_cool = 1; cyc(1); ot_cool = 0;
        en = 1;
        for (int i = 0; i < 300 && ss != 7'(SSC); i++) cyc(1);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual 1 expected 0");
        summary();
    end

    initial begin
        int seen_pg;
        uvlo = 1;
        cyc(3);
        rst = 0;
        cyc(1);
        // R1 reset state
        chk("R1 code", ss, 0);
        chk("R1 outputs", {pwm_en, ls_en, pgood, en_dis, fault}, 0);

        // R2 bad feedback pin holds ramp
        fb_bad = 1; en = 1;
        cyc(10);
        chk("R2 code held", ss, 0);
        chk("R2 pwm off", pwm_en, 0);
        fb_bad = 0;
        cyc(2);
        chk("R2 released pwm", pwm_en, 1);
        // R3 one step per cycle
        begin
            int c0;
            c0 = ss; cyc(5);
            chk("R3 step", ss, c0 + 5);
        end
        // R7 undervoltage ignored during the ramp
        fb_under = 1; cyc(30); fb_under = 0;
        chk("R7 ignored in ramp", fault, 0);
        // R4 lower switch threshold
        for (int i = 0; i < 200 && ss != 7'(LSP - 1); i++) cyc(1);
        chk("R4 ls before", ls_en, 0);
        chk("R5 pg in ramp", pgood, 0);
        cyc(1);
        chk("R4 ls at point", {ss, ls_en}, {7'(LSP), 1'b1});
        for (int i = 0; i < 200 && ss != 7'(SSC); i++) cyc(1);
        chk("R5 pg at end", pgood, 1);
        cyc(3);
        chk("R3 holds full", ss, SSC);

        // table walk of qualified protections in the run phase
        for (int v = 0; v < 10; v++) begin
            restart();
            set_flag(int'(VEC[v][15:12]), 1'b1);
            repeat (int'(VEC[v][11:4])) @(posedge clk);
            @(negedge clk);
            set_flag(int'(VEC[v][15:12]), 1'b0);
            chk({VREQ[v], " fault"}, fault, int'(VEC[v][1]));
            chk({VREQ[v], " pgood"}, pgood, int'(VEC[v][0]));
        end

        // R11 hot restart refused until cool
        restart();
        ot_hot = 1; cyc(1); ot_hot = 0;
        chk("R11 fault", fault, 1);
        en = 0; cyc(2); en = 1; cyc(6);
        chk("R11 no restart while hot", pwm_en, 0);
        ot_cool = 1; cyc(1); ot_cool = 0; cyc(3);
        chk("R11 restart after cool", pwm_en, 1);

        // R12 fault latched, cleared by enable toggle
        for (int i = 0; i < 300 && ss != 7'(SSC); i++) cyc(1);
        fb_over = 1; cyc(2); fb_over = 0; cyc(5);
        chk("R12 latched", {fault, en_dis, pwm_en, ls_en}, 4'b1100);
        en = 0; cyc(1);
        chk("R12 cleared", {fault, en_dis, pwm_en}, 0);
        chk("R1 standby code", ss, 0);
        en = 1; cyc(4);
        chk("R12 new ramp", {pwm_en, ss}, {1'b1, 7'd2});

        // R8 overvoltage during ramp; R9 current limit during ramp
        fb_over = 1; cyc(2); fb_over = 0;
        chk("R8 in ramp", fault, 1);
        restart(); en = 0; cyc(1); en = 1; cyc(6);
        ilim = 1; cyc(16); ilim = 0;
        chk("R9 in ramp", {fault, pwm_en}, 2'b10);

        // R14 one-cycle gap restarts the count
        restart();
        ilim = 1; cyc(10); ilim = 0; cyc(1); ilim = 1; cyc(10); ilim = 0;
        chk("R14 gap clears", fault, 0);

        // R13 lockout loss mid-ramp
        en = 0; cyc(1); en = 1; cyc(20);
        uvlo = 0; cyc(1);
        chk("R13 cleared", {ss, pwm_en}, 0);
        uvlo = 1;

        // R9 coincidence: 16th trip on the final ramp edge
        for (int i = 0; i < 200 && ss != 7'(SSC - 16); i++) cyc(1);
        ilim = 1; seen_pg = 0;
        for (int i = 0; i < 16; i++) begin
            cyc(1);
            if (pgood) seen_pg = 1;
        end
        ilim = 0;
        cyc(2);
        if (pgood) seen_pg = 1;
        chk("R9 coincide fault", fault, 1);
        chk("R9 coincide pg never", seen_pg, 0);

        // R6/R8 coincidence: window and overvoltage together
        restart();
        fb_over = 1; fb_ow = 1; cyc(2); fb_over = 0; fb_ow = 0;
        chk("R8 coincide fault", fault, 1);
        chk("R6 coincide pg", pgood, 0);

        summary();
    end
endmodule